// File: doc/BRIEF.md
# DRAM Refresh Sequencer with Row/Column Address Multiplexing

This block sits between a requester and a dynamic memory array that has a single shared address bus. It accepts word read and write requests over a valid/ready handshake. Each request address is split into a row part and a column part. The row part is placed on the shared bus first, under a row strobe. The column part follows, under a column strobe, while the row strobe stays high. When the row strobe drops, the array writes the opened row back.

A periodic tick from outside asks for a refresh. An internal counter holds the next row to refresh. A refresh opens that row and then closes it with no column access, so the array reads the row and restores it unchanged. The counter then moves to the next row and wraps after the last one. While a refresh is waiting or running, the block holds the request port off. An access that has already been accepted always runs to completion before a refresh starts.

By default the block uses 11 row bits, 11 column bits and 4 data bits, which gives a 2048 by 2048 by 4 organisation. Each request therefore carries a 22-bit address.

Top module: `dram_refresh_mux`

## Requirements
- R1: One cycle after a request is accepted, `mem_row_stb_o` is 1, `mem_col_stb_o` is 0, and `mem_addr_o` carries the upper ROW_W bits of the request address, zero-extended.
- R2: In the cycle after the row phase, `mem_col_stb_o` and `mem_row_stb_o` are both 1. In that cycle `mem_addr_o` carries the lower COL_W bits of the request address, and `mem_we_o` equals the request's write flag. `mem_col_stb_o` is never 1 unless `mem_row_stb_o` is 1.
- R3: The column cycle is followed by one cycle with both strobes at 0. In the cycle after that, a read pulses `rsp_valid_o` for one cycle with `rsp_rdata_o` equal to the data last written to that address. A write produces no response pulse.
- R4: A refresh takes the following form. One cycle has `mem_row_stb_o` at 1 with `mem_addr_o` set to the refresh row. The next cycle has both strobes at 0. `mem_col_stb_o` stays 0 for the whole refresh.
- R5: The refresh row starts at 0 after reset and increases by one with each refresh. After row 2^ROW_W-1 it wraps to 0.
- R6: `req_ready_o` is 0 from the cycle after a tick until the refresh completes. A request held valid during that time is not started until the refresh has finished.
- R7: A tick that arrives while an access is in progress does not cut the access short. The access completes, and the refresh starts next, ahead of any new request.
- R8: After reset, `req_ready_o` is 1, both strobes are 0 and `rsp_valid_o` is 0.
- R9: A refresh leaves the stored data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| refresh_tick_i | input | 1 | Periodic refresh request pulse |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ROW_W+COL_W | Word address, row in upper bits |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | DATA_W | Read data |
| mem_addr_o | output | max(ROW_W,COL_W) | Shared row/column address bus |
| mem_row_stb_o | output | 1 | Row strobe, high while a row is open |
| mem_col_stb_o | output | 1 | Column strobe |
| mem_we_o | output | 1 | Column write enable |
| mem_wdata_o | output | DATA_W | Data to array |
| mem_rdata_i | input | DATA_W | Data from array, registered one cycle after the column strobe |

## Verification
The bench uses row and column widths that differ, so the zero-extension of the row onto the wider bus is exercised. A design that swapped the address halves, or took the wrong slice, would put a wrong value on the bus in the row or column phase. A dozen back-to-back refreshes cross the counter wrap, which catches a counter that skips a row, sticks, or wraps at the wrong point. A tick is raised in the middle of an access, and a request is held valid during a refresh. These two cases expose a sequencer that aborts the access, lets the request slip ahead of the refresh, or lowers ready too late. Data written before many refreshes is read back afterwards, which catches a refresh that fires a column write or closes the wrong row.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ROW, S_COL, S_PRE, S_RF_ROW, S_RF_PRE
  } seq_state_e;

  typedef enum logic [1:0] {
    ASEL_ROW, ASEL_COL, ASEL_RFSH
  } addr_sel_e;
endpackage

// File: rtl/dram_rfsh_ctr.sv
module dram_rfsh_ctr #(
  parameter int ROW_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             take_i,
  input  logic             adv_i,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);
  localparam logic [ROW_W-1:0] LastRow = {ROW_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      row_o  <= '0;
    end else begin
      pend_o <= tick_i | (pend_o & ~take_i);
      if (adv_i) row_o <= (row_o == LastRow) ? '0 : row_o + 1'b1;
    end
  end

  p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && row_o == LastRow |=> row_o == '0);
  p_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(row_o));
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
  parameter int ROW_W = 11,
  parameter int COL_W = 11,
  parameter int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  dram_ctl_pkg::addr_sel_e sel_i,
  input  logic [ROW_W-1:0]        req_row_i,
  input  logic [COL_W-1:0]        req_col_i,
  input  logic [ROW_W-1:0]        rf_row_i,
  output logic [MUX_W-1:0]        addr_o
);
  import dram_ctl_pkg::*;
  logic [MUX_W-1:0] row_x, col_x, rf_x;

  generate
    if (MUX_W > ROW_W) begin : g_row_pad
      assign row_x = {{(MUX_W-ROW_W){1'b0}}, req_row_i};
      assign rf_x  = {{(MUX_W-ROW_W){1'b0}}, rf_row_i};
    end else begin : g_row_full
      assign row_x = req_row_i;
      assign rf_x  = rf_row_i;
    end
    if (MUX_W > COL_W) begin : g_col_pad
      assign col_x = {{(MUX_W-COL_W){1'b0}}, req_col_i};
    end else begin : g_col_full
      assign col_x = req_col_i;
    end
  endgenerate

  always_comb begin
    unique case (sel_i)
      ASEL_COL:  addr_o = col_x;
      ASEL_RFSH: addr_o = rf_x;
      default:   addr_o = row_x;
    endcase
  end
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm #(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 11,
  parameter int DATA_W = 4,
  localparam int AW    = ROW_W + COL_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pend_i,
  output logic                    take_o,
  output logic                    adv_o,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic                    req_we_i,
  input  logic [AW-1:0]           req_addr_i,
  input  logic [DATA_W-1:0]       req_wdata_i,
  output logic                    rsp_valid_o,
  output logic [DATA_W-1:0]       rsp_rdata_o,
  output dram_ctl_pkg::addr_sel_e sel_o,
  output logic [ROW_W-1:0]        row_q_o,
  output logic [COL_W-1:0]        col_q_o,
  output logic                    row_stb_o,
  output logic                    col_stb_o,
  output logic                    we_o,
  output logic [DATA_W-1:0]       wdata_o,
  input  logic [DATA_W-1:0]       rdata_i
);
  import dram_ctl_pkg::*;

  seq_state_e state_q, state_d;
  logic       we_q;
  logic       accept;

  assign req_ready_o = (state_q == S_IDLE) && !pend_i;
  assign accept      = req_ready_o && req_valid_i;
  assign take_o      = (state_q == S_IDLE) && pend_i;
  assign adv_o       = (state_q == S_RF_ROW);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (pend_i) state_d = S_RF_ROW;
                else if (req_valid_i) state_d = S_ROW;
      S_ROW:    state_d = S_COL;
      S_COL:    state_d = S_PRE;
      S_PRE:    state_d = S_IDLE;
      S_RF_ROW: state_d = S_RF_PRE;
      S_RF_PRE: state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      we_q        <= 1'b0;
      row_q_o     <= '0;
      col_q_o     <= '0;
      wdata_o     <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_o <= (state_q == S_PRE) && !we_q;
      if (state_q == S_PRE) rsp_rdata_o <= rdata_i;
      if (accept) begin
        we_q    <= req_we_i;
        row_q_o <= req_addr_i[AW-1:COL_W];
        col_q_o <= req_addr_i[COL_W-1:0];
        wdata_o <= req_wdata_i;
      end
    end
  end

  always_comb begin
    row_stb_o = (state_q == S_ROW) || (state_q == S_COL) || (state_q == S_RF_ROW);
    col_stb_o = (state_q == S_COL);
    we_o      = (state_q == S_COL) && we_q;
    if (state_q == S_COL)         sel_o = ASEL_COL;
    else if (state_q == S_RF_ROW) sel_o = ASEL_RFSH;
    else                          sel_o = ASEL_ROW;
  end

  p_col_under_row_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_stb_o |-> row_stb_o);
  p_row_before_col_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> row_stb_o && !col_stb_o ##1 col_stb_o);
  p_rf_no_col_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RF_ROW || state_q == S_RF_PRE) |-> !col_stb_o);
  p_pend_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i && state_q == S_IDLE |=> state_q == S_RF_ROW);
  p_rsp_one_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

// File: rtl/dram_refresh_mux.sv
module dram_refresh_mux #(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 11,
  parameter int DATA_W = 4,
  localparam int AW    = ROW_W + COL_W,
  localparam int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              refresh_tick_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [MUX_W-1:0]  mem_addr_o,
  output logic              mem_row_stb_o,
  output logic              mem_col_stb_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  import dram_ctl_pkg::*;

  logic             pend, take, adv;
  logic [ROW_W-1:0] rf_row, row_q;
  logic [COL_W-1:0] col_q;
  addr_sel_e        sel;

  dram_rfsh_ctr #(.ROW_W(ROW_W)) u_ctr (
    .clk_i, .rst_ni, .tick_i(refresh_tick_i), .take_i(take), .adv_i(adv),
    .pend_o(pend), .row_o(rf_row)
  );

  dram_seq_fsm #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni, .pend_i(pend), .take_o(take), .adv_o(adv),
    .req_valid_i, .req_ready_o, .req_we_i, .req_addr_i, .req_wdata_i,
    .rsp_valid_o, .rsp_rdata_o, .sel_o(sel), .row_q_o(row_q), .col_q_o(col_q),
    .row_stb_o(mem_row_stb_o), .col_stb_o(mem_col_stb_o), .we_o(mem_we_o),
    .wdata_o(mem_wdata_o), .rdata_i(mem_rdata_i)
  );

  dram_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .MUX_W(MUX_W)) u_mux (
    .sel_i(sel), .req_row_i(row_q), .req_col_i(col_q), .rf_row_i(rf_row),
    .addr_o(mem_addr_o)
  );

  p_tick_stalls_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_tick_i |=> !req_ready_o);
endmodule

// File: tb/tb_dram_refresh_mux.sv
module tb_dram_refresh_mux;
  localparam int ClkPeriod = 10;
  localparam int RW = 3, CW = 4, DW = 4;
  localparam int NROW = 1 << RW, NCOL = 1 << CW;
  localparam int AW = RW + CW, MW = (RW > CW) ? RW : CW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, row_stb, col_stb, mem_we;
  logic [DW-1:0] rsp_rdata, mem_wdata, mem_rdata;
  logic [MW-1:0] mem_addr;

  always #(ClkPeriod/2) clk = ~clk;

  dram_refresh_mux #(.ROW_W(RW), .COL_W(CW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .refresh_tick_i(tick),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_addr_o(mem_addr), .mem_row_stb_o(row_stb), .mem_col_stb_o(col_stb),
    .mem_we_o(mem_we), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  // behavioural array: row buffer opened on strobe rise, restored on fall
  logic [DW-1:0] arr [NROW][NCOL];
  logic [DW-1:0] rbuf [NCOL];
  logic [RW-1:0] open_row = '0;
  logic          prev_row = 1'b0;
  initial begin
    for (int r = 0; r < NROW; r++)
      for (int c = 0; c < NCOL; c++) arr[r][c] = '0;
    for (int c = 0; c < NCOL; c++) rbuf[c] = '0;
    mem_rdata = '0;
  end
  always @(posedge clk) begin
    if (row_stb && !prev_row) begin
      for (int c = 0; c < NCOL; c++) rbuf[c] <= arr[mem_addr[RW-1:0]][c];
      open_row <= mem_addr[RW-1:0];
    end
    if (row_stb && col_stb) begin
      if (mem_we) rbuf[mem_addr[CW-1:0]] <= mem_wdata;
      else mem_rdata <= rbuf[mem_addr[CW-1:0]];
    end
    if (!row_stb && prev_row)
      for (int c = 0; c < NCOL; c++) arr[open_row][c] <= rbuf[c];
    prev_row <= row_stb;
  end

  int checks = 0, failures = 0, rf_exp = 0;
  logic [DW-1:0] shadow [NROW*NCOL];
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_access(input bit we, input int addr, input int data);
    int row = addr >> CW, col = addr % NCOL;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = AW'(addr); req_wdata = DW'(data);
    @(negedge clk);
    req_valid = 1'b0;
    chk(row_stb && !col_stb, "R1 row strobe", {row_stb, col_stb}, 2);
    chk(int'(mem_addr) == row, "R1 row addr", mem_addr, row);
    @(negedge clk);
    chk(row_stb && col_stb, "R2 col strobe", {row_stb, col_stb}, 3);
    chk(int'(mem_addr) == col, "R2 col addr", mem_addr, col);
    chk(mem_we == we, "R2 we", mem_we, we);
    @(negedge clk);
    chk(!row_stb && !col_stb, "R3 release", {row_stb, col_stb}, 0);
    @(negedge clk);
    if (we) begin
      shadow[addr] = DW'(data);
      chk(!rsp_valid, "R3 no rsp on write", rsp_valid, 0);
    end else begin
      chk(rsp_valid, "R3 rsp valid", rsp_valid, 1);
      chk(rsp_rdata == shadow[addr], "R3 rdata", rsp_rdata, shadow[addr]);
    end
  endtask

  task automatic do_refresh();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk(!req_ready, "R6 ready low on pend", req_ready, 0);
    @(negedge clk);
    chk(row_stb && !col_stb, "R4 rf row strobe", {row_stb, col_stb}, 2);
    chk(int'(mem_addr) == rf_exp, "R5 rf row", mem_addr, rf_exp);
    chk(!req_ready, "R6 ready low in rf", req_ready, 0);
    @(negedge clk);
    chk(!row_stb && !col_stb, "R4 rf release", {row_stb, col_stb}, 0);
    @(negedge clk);
    chk(req_ready, "R6 ready back", req_ready, 1);
    rf_exp = (rf_exp + 1) % NROW;
  endtask

  task automatic t_reset();
    for (int i = 0; i < NROW*NCOL; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R8 ready", req_ready, 1);
    chk(!row_stb && !col_stb, "R8 strobes", {row_stb, col_stb}, 0);
    chk(!rsp_valid, "R8 rsp", rsp_valid, 0);
  endtask

  task automatic t_basic();
    do_access(1'b1, 'h00, 'h5);
    do_access(1'b1, 'h7F, 'hA);
    do_access(1'b1, 'h3C, 'hF);
    do_access(1'b1, 'h41, 'h3);
    do_access(1'b0, 'h00, 0);
    do_access(1'b0, 'h7F, 0);
    do_access(1'b0, 'h3C, 0);
    do_access(1'b0, 'h41, 0);
    do_access(1'b0, 'h12, 0);
  endtask

  task automatic t_refresh_wrap();
    for (int i = 0; i < NROW + 4; i++) do_refresh();   // R5 crosses the wrap
  endtask

  task automatic t_preserve();
    for (int i = 0; i < NROW; i++) do_access(1'b1, i*NCOL + (i % NCOL), i + 1);
    for (int i = 0; i < NROW; i++) do_refresh();
    for (int i = 0; i < NROW; i++) do_access(1'b0, i*NCOL + (i % NCOL), 0);  // R9
    do_access(1'b0, 'h7F, 0);
  endtask

  task automatic t_tick_mid_access();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = AW'('h7F);
    @(negedge clk);
    req_valid = 1'b0; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk(col_stb && int'(mem_addr) == 'hF, "R7 access continues", mem_addr, 'hF);
    @(negedge clk);
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == shadow['h7F], "R7 access data", rsp_rdata, shadow['h7F]);
    chk(!req_ready, "R7 ready low before rf", req_ready, 0);
    @(negedge clk);
    chk(row_stb && !col_stb && int'(mem_addr) == rf_exp, "R7 rf follows", mem_addr, rf_exp);
    @(negedge clk);
    @(negedge clk);
    chk(req_ready, "R7 ready after rf", req_ready, 1);
    rf_exp = (rf_exp + 1) % NROW;
  endtask

  task automatic t_held_request();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    req_valid = 1'b1; req_we = 1'b0; req_addr = AW'('h41);
    @(negedge clk);
    chk(int'(mem_addr) == rf_exp && !col_stb, "R6 rf before held req", mem_addr, rf_exp);
    @(negedge clk);
    chk(!req_ready && !row_stb, "R6 still stalled", req_ready, 0);
    @(negedge clk);
    chk(req_ready, "R6 ready after rf", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(row_stb && int'(mem_addr) == ('h41 >> CW), "R6 held req starts", mem_addr, 'h41 >> CW);
    repeat (3) @(negedge clk);
    chk(rsp_rdata == shadow['h41], "R6 held req data", rsp_rdata, shadow['h41]);
    rf_exp = (rf_exp + 1) % NROW;
  endtask

  initial begin
    t_reset();
    t_basic();
    t_refresh_wrap();
    t_preserve();
    t_tick_mid_access();
    t_held_request();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule